// File: doc/BRIEF.md
# Sequenced Register-Pair Adder

This block performs a 16-bit "add a register pair into HL" operation on a datapath whose only arithmetic unit is a byte-wide adder. It contains the byte register file (B, C, D, E, H, L, the accumulator and the flags), a 16-bit stack pointer, a hidden save register used to park the accumulator, a temporary operand register and an internal inter-byte carry. When a start strobe arrives with a matching opcode, the block runs a fixed schedule: a four-clock fetch phase, then a three-clock idle-bus phase that sums the low bytes, then a three-clock idle-bus phase that sums the high bytes with the carry from the low half.

The accumulator is borrowed as the adder's first operand during the two idle-bus phases. It is saved before the first use and put back at the end, so the only architecturally visible effects are the new HL value and the carry flag. A simple write port loads the registers while the block is idle, and every register can be read back continuously.

Top module: `pair_add_seq`

## Requirements
- R1: An opcode is accepted only if bits [7:6] are 00 and bits [3:0] are 1001. Bits [5:4] select the source pair: 00 = BC, 01 = DE, 10 = HL, 11 = SP. A start strobe with any other opcode is ignored: busy stays low and no register changes.
- R2: After an accepted instruction, HL equals (HL + source pair) mod 2^16. A source pair other than HL keeps its value (for example, HL = 0x5050 plus BC = 0x4050 gives 0x90A0, and BC stays 0x4050).
- R3: With source pair HL, the result is twice the original HL, because each source byte is sampled before it is overwritten.
- R4: The carry flag (flags bit 0) becomes the carry out of the 16-bit sum. The other seven flag bits do not change.
- R5: The accumulator holds its original value once the instruction has finished.
- R6: busy is high for exactly 10 consecutive cycles, starting in the cycle after the clock edge that accepts the start strobe.
- R7: bus_idle is high in busy cycles 5 to 10 and low at all other times.
- R8: done is high for exactly one cycle, which is the tenth busy cycle.
- R9: A start strobe while busy is ignored. The running instruction ends on its original schedule with its original operands, and no second instruction follows it.
- R10: When wr_en is high and the block is idle, wr_data is written into the register chosen by wr_sel (0 = B, 1 = C, 2 = D, 3 = E, 4 = H, 5 = L, 6 = A, 7 = flags, 8 = SP high byte, 9 = SP low byte). The new value is visible in the next cycle. Writes while busy are ignored.
- R11: The low-byte add does not use the incoming carry flag, so the result does not depend on the carry value before the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe for the opcode on `opcode` |
| opcode | input | 8 | Instruction byte |
| wr_en | input | 1 | Register write enable (idle only) |
| wr_sel | input | 4 | Register select for writes |
| wr_data | input | 8 | Write data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last cycle of the instruction |
| bus_idle | output | 1 | Idle-bus phase status |
| reg_b | output | 8 | B register |
| reg_c | output | 8 | C register |
| reg_d | output | 8 | D register |
| reg_e | output | 8 | E register |
| reg_h | output | 8 | H register |
| reg_l | output | 8 | L register |
| reg_a | output | 8 | Accumulator |
| reg_f | output | 8 | Flags (bit 0 = carry) |
| reg_sp | output | 16 | Stack pointer |

## Verification
Two situations are hard to reach from the ports. The first is a stray start strobe or register write that lands in the middle of the schedule. The bench injects both during selected runs and then checks that the result, the source pair and the end time are undisturbed. The second is a low-byte carry that must come from the adder and not from the stale flag. The sweep pairs boundary operands (0x00FF, 0xFFFF, 0x8000, ...) with the carry flag preset to both values, and adds the HL self-doubling case, where the sources are also the destinations.

// File: rtl/pas_pkg.sv
package pas_pkg;
   localparam int OP_W = 8;

   typedef enum logic [1:0] {
      PR_BC = 2'd0,
      PR_DE = 2'd1,
      PR_HL = 2'd2,
      PR_SP = 2'd3
   } pair_e;

   typedef enum logic [3:0] {
      SEL_B   = 4'd0,
      SEL_C   = 4'd1,
      SEL_D   = 4'd2,
      SEL_E   = 4'd3,
      SEL_H   = 4'd4,
      SEL_L   = 4'd5,
      SEL_A   = 4'd6,
      SEL_F   = 4'd7,
      SEL_SPH = 4'd8,
      SEL_SPL = 4'd9
   } rsel_e;

   function automatic logic is_pair_add(input logic [OP_W-1:0] op);
      return (op[7:6] == 2'b00) && (op[3:0] == 4'b1001);
   endfunction

   function automatic pair_e pair_of(input logic [OP_W-1:0] op);
      return pair_e'(op[5:4]);
   endfunction
endpackage

// File: rtl/pas_alu.sv
module pas_alu #(
   parameter int DW     = 8,
   parameter int RIPPLE = 0
) (
   input  logic [DW-1:0] op_a,
   input  logic [DW-1:0] op_b,
   input  logic          cin,
   output logic [DW-1:0] sum,
   output logic          cout
);
   generate
      if (RIPPLE != 0) begin : g_ripple
         logic [DW:0] cc;
         assign cc[0] = cin;
         for (genvar i = 0; i < DW; i++) begin : g_bit
            assign sum[i]  = op_a[i] ^ op_b[i] ^ cc[i];
            assign cc[i+1] = (op_a[i] & op_b[i]) | (cc[i] & (op_a[i] ^ op_b[i]));
         end
         assign cout = cc[DW];
      end else begin : g_behav
         logic [DW:0] wide;
         assign wide = {1'b0, op_a} + {1'b0, op_b} + {{DW{1'b0}}, cin};
         assign sum  = wide[DW-1:0];
         assign cout = wide[DW];
      end
   endgenerate
endmodule

// File: rtl/pas_seq.sv
module pas_seq #(
   parameter int OF_CYC = 4,
   parameter int BI_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy,
   output logic done,
   output logic bus_idle,
   output logic st_save,
   output logic st_lo,
   output logic st_hiop,
   output logic st_hi,
   output logic st_rest
);
   localparam int TOTAL = OF_CYC + 2 * BI_CYC;
   localparam int CW    = $clog2(TOTAL);
   localparam int S1    = OF_CYC;
   localparam int S2    = OF_CYC + BI_CYC;
   localparam int LAST  = TOTAL - 1;

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (!busy) begin
         if (go) begin
            busy <= 1'b1;
            cnt  <= '0;
         end
      end else if (cnt == CW'(LAST)) begin
         busy <= 1'b0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign done     = busy && (cnt == CW'(LAST));
   assign bus_idle = busy && (cnt >= CW'(S1));
   assign st_save  = busy && (cnt == CW'(S1));
   assign st_lo    = busy && (cnt == CW'(S1 + 1));
   assign st_hiop  = busy && (cnt == CW'(S2));
   assign st_hi    = busy && (cnt == CW'(S2 + 1));
   assign st_rest  = busy && (cnt == CW'(LAST));
endmodule

// File: rtl/pas_regs.sv
module pas_regs
   import pas_pkg::*;
#(
   parameter int DW     = 8,
   parameter int CY_BIT = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy,
   input  logic          wr_en,
   input  logic [3:0]    wr_sel,
   input  logic [DW-1:0] wr_data,
   input  pair_e         pair,
   input  logic          st_save,
   input  logic          st_lo,
   input  logic          st_hiop,
   input  logic          st_hi,
   input  logic          st_rest,
   input  logic [DW-1:0] alu_sum,
   input  logic          alu_cout,
   output logic [DW-1:0] alu_a,
   output logic [DW-1:0] alu_b,
   output logic          alu_cin,
   output logic [DW-1:0] q_b,
   output logic [DW-1:0] q_c,
   output logic [DW-1:0] q_d,
   output logic [DW-1:0] q_e,
   output logic [DW-1:0] q_h,
   output logic [DW-1:0] q_l,
   output logic [DW-1:0] q_a,
   output logic [DW-1:0] q_f,
   output logic [2*DW-1:0] q_sp
);
   logic [DW-1:0] w_save, tmp;
   logic          cy_mid;
   logic [DW-1:0] src_lo, src_hi;

   always_comb begin
      case (pair)
         PR_BC:   begin src_lo = q_c;          src_hi = q_b;             end
         PR_DE:   begin src_lo = q_e;          src_hi = q_d;             end
         PR_HL:   begin src_lo = q_l;          src_hi = q_h;             end
         default: begin src_lo = q_sp[DW-1:0]; src_hi = q_sp[2*DW-1:DW]; end
      endcase
   end

   assign alu_a   = q_a;
   assign alu_b   = tmp;
   assign alu_cin = st_hi ? cy_mid : 1'b0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_b <= '0; q_c <= '0; q_d <= '0; q_e <= '0;
         q_h <= '0; q_l <= '0; q_a <= '0; q_f <= '0;
         q_sp   <= '0;
         w_save <= '0;
         tmp    <= '0;
         cy_mid <= 1'b0;
      end else if (!busy) begin
         if (wr_en) begin
            case (wr_sel)
               SEL_B:   q_b <= wr_data;
               SEL_C:   q_c <= wr_data;
               SEL_D:   q_d <= wr_data;
               SEL_E:   q_e <= wr_data;
               SEL_H:   q_h <= wr_data;
               SEL_L:   q_l <= wr_data;
               SEL_A:   q_a <= wr_data;
               SEL_F:   q_f <= wr_data;
               SEL_SPH: q_sp[2*DW-1:DW] <= wr_data;
               SEL_SPL: q_sp[DW-1:0]    <= wr_data;
               default: ;
            endcase
         end
      end else begin
         if (st_save) begin
            w_save <= q_a;
            q_a    <= q_l;
            tmp    <= src_lo;
         end
         if (st_lo) begin
            q_l    <= alu_sum;
            cy_mid <= alu_cout;
         end
         if (st_hiop) begin
            q_a <= q_h;
            tmp <= src_hi;
         end
         if (st_hi) begin
            q_h         <= alu_sum;
            q_f[CY_BIT] <= alu_cout;
         end
         if (st_rest) begin
            q_a <= w_save;
         end
      end
   end
endmodule

// File: rtl/pair_add_seq.sv
module pair_add_seq
   import pas_pkg::*;
#(
   parameter int DW     = 8,
   parameter int OF_CYC = 4,
   parameter int BI_CYC = 3,
   parameter int CY_BIT = 0,
   parameter int RIPPLE = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [7:0]      opcode,
   input  logic            wr_en,
   input  logic [3:0]      wr_sel,
   input  logic [DW-1:0]   wr_data,
   output logic            busy,
   output logic            done,
   output logic            bus_idle,
   output logic [DW-1:0]   reg_b,
   output logic [DW-1:0]   reg_c,
   output logic [DW-1:0]   reg_d,
   output logic [DW-1:0]   reg_e,
   output logic [DW-1:0]   reg_h,
   output logic [DW-1:0]   reg_l,
   output logic [DW-1:0]   reg_a,
   output logic [DW-1:0]   reg_f,
   output logic [2*DW-1:0] reg_sp
);
   generate
      if (DW < 2) begin : g_bad_dw
         $error("pair_add_seq: DW must be at least 2");
      end
      if (OF_CYC < 2) begin : g_bad_of
         $error("pair_add_seq: OF_CYC must be at least 2");
      end
      if (BI_CYC < 2) begin : g_bad_bi
         $error("pair_add_seq: BI_CYC must be at least 2");
      end
      if (CY_BIT < 0 || CY_BIT >= DW) begin : g_bad_cy
         $error("pair_add_seq: CY_BIT must lie inside the flag byte");
      end
   endgenerate

   logic  accept;
   pair_e ir_pair;
   logic  st_save, st_lo, st_hiop, st_hi, st_rest;
   logic [DW-1:0] alu_a, alu_b, alu_sum;
   logic          alu_cin, alu_cout;

   assign accept = start && !busy && is_pair_add(opcode);

   always_ff @(posedge clk) begin
      if (!rst_n)      ir_pair <= PR_BC;
      else if (accept) ir_pair <= pair_of(opcode);
   end

   pas_seq #(.OF_CYC(OF_CYC), .BI_CYC(BI_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(accept),
      .busy(busy), .done(done), .bus_idle(bus_idle),
      .st_save(st_save), .st_lo(st_lo), .st_hiop(st_hiop),
      .st_hi(st_hi), .st_rest(st_rest)
   );

   pas_alu #(.DW(DW), .RIPPLE(RIPPLE)) u_alu (
      .op_a(alu_a), .op_b(alu_b), .cin(alu_cin),
      .sum(alu_sum), .cout(alu_cout)
   );

   pas_regs #(.DW(DW), .CY_BIT(CY_BIT)) u_regs (
      .clk(clk), .rst_n(rst_n), .busy(busy),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .pair(ir_pair),
      .st_save(st_save), .st_lo(st_lo), .st_hiop(st_hiop),
      .st_hi(st_hi), .st_rest(st_rest),
      .alu_sum(alu_sum), .alu_cout(alu_cout),
      .alu_a(alu_a), .alu_b(alu_b), .alu_cin(alu_cin),
      .q_b(reg_b), .q_c(reg_c), .q_d(reg_d), .q_e(reg_e),
      .q_h(reg_h), .q_l(reg_l), .q_a(reg_a), .q_f(reg_f),
      .q_sp(reg_sp)
   );
endmodule

// File: rtl/pas_chk.sv
module pas_chk #(
   parameter int DW     = 8,
   parameter int OF_CYC = 4,
   parameter int BI_CYC = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            done,
   input logic            bus_idle,
   input logic            wr_en,
   input logic [DW-1:0]   reg_b,
   input logic [DW-1:0]   reg_c,
   input logic [DW-1:0]   reg_d,
   input logic [DW-1:0]   reg_e,
   input logic [DW-1:0]   reg_h,
   input logic [DW-1:0]   reg_l,
   input logic [DW-1:0]   reg_a,
   input logic [DW-1:0]   reg_f,
   input logic [2*DW-1:0] reg_sp
);
   localparam int TOTAL = OF_CYC + 2 * BI_CYC;
   localparam int KW    = $clog2(TOTAL) + 1;

   logic [KW-1:0] k;
   logic [DW-1:0] a_cap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         k     <= '0;
         a_cap <= '0;
      end else begin
         k <= busy ? k + 1'b1 : '0;
         if (busy && k == '0) a_cap <= reg_a;
      end
   end

   // R6
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && k < KW'(TOTAL - 1)) |=> busy);
   // R6
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && k == KW'(TOTAL - 1)) |=> !busy);
   // R8
   done_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done == (busy && k == KW'(TOTAL - 1)));
   // R7
   idle_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_idle == (busy && k >= KW'(OF_CYC)));
   // R5
   acc_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (reg_a == a_cap));
   // R2
   src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(reg_b) && $stable(reg_c) && $stable(reg_d) &&
                $stable(reg_e) && $stable(reg_sp)));
   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !wr_en) |=> ($stable(reg_h) && $stable(reg_l) &&
                             $stable(reg_a) && $stable(reg_f)));
endmodule

bind pair_add_seq pas_chk #(.DW(DW), .OF_CYC(OF_CYC), .BI_CYC(BI_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .bus_idle(bus_idle),
   .wr_en(wr_en), .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d), .reg_e(reg_e),
   .reg_h(reg_h), .reg_l(reg_l), .reg_a(reg_a), .reg_f(reg_f), .reg_sp(reg_sp)
);

// File: tb/sim_pair_add_seq.sv
module sim_pair_add_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_sel = 4'd0;
   logic [7:0]  wr_data = 8'h00;
   logic        busy, done, bus_idle;
   logic [7:0]  reg_b, reg_c, reg_d, reg_e, reg_h, reg_l, reg_a, reg_f;
   logic [15:0] reg_sp;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   pair_add_seq u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .busy(busy), .done(done), .bus_idle(bus_idle),
      .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d), .reg_e(reg_e),
      .reg_h(reg_h), .reg_l(reg_l), .reg_a(reg_a), .reg_f(reg_f),
      .reg_sp(reg_sp)
   );

   task automatic chk(input logic ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [15:0] pick(input int i);
      case (i)
         0: return 16'h0000;
         1: return 16'hFFFF;
         2: return 16'h00FF;
         3: return 16'hFF00;
         4: return 16'h0001;
         5: return 16'h8000;
         6: return 16'h7FFF;
         default: return 16'h13A7;
      endcase
   endfunction

   // Loads all registers, runs one instruction, checks status per cycle and results.
   task automatic run(input int pr, input logic [15:0] hl, input logic [15:0] src,
                      input logic [7:0] av, input logic [7:0] fv, input logic noise);
      logic [15:0] bc, de, sp, s_use, other;
      logic [16:0] sum;
      logic [2:0]  st_exp;
      bc = (pr == 0) ? src : src ^ 16'h2C4B;
      de = (pr == 1) ? src : src ^ 16'h5A17;
      sp = (pr == 3) ? src : src ^ 16'h0F3C;
      wr(4'd0, bc[15:8]); wr(4'd1, bc[7:0]);
      wr(4'd2, de[15:8]); wr(4'd3, de[7:0]);
      wr(4'd8, sp[15:8]); wr(4'd9, sp[7:0]);
      wr(4'd4, hl[15:8]); wr(4'd5, hl[7:0]);
      wr(4'd6, av);       wr(4'd7, fv);
      s_use = (pr == 2) ? hl : src;
      sum = {1'b0, hl} + {1'b0, s_use};
      @(negedge clk);
      opcode = {2'b00, 2'(pr), 4'b1001};
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int k = 1; k <= 10; k++) begin
         if (k > 1) @(negedge clk);
         st_exp = {1'b1, (k >= 5), (k == 10)};
         // R6 R7 R8: busy, bus_idle, done per cycle
         chk({busy, bus_idle, done} == st_exp, "R6/R7/R8 status", {busy, bus_idle, done}, st_exp);
         if (noise && k == 3) begin
            start = 1'b1; opcode = {2'b00, 2'(3 - pr), 4'b1001};
         end
         if (noise && k == 4) begin
            start = 1'b0; wr_en = 1'b1; wr_sel = 4'd0; wr_data = ~bc[15:8];
         end
         if (noise && k == 5) wr_en = 1'b0;
      end
      @(negedge clk);
      // R9: no second instruction after the injected strobe
      chk(busy == 1'b0, "R9 busy cleared", busy, 0);
      if (pr == 2)
         chk({reg_h, reg_l} == sum[15:0], "R3 doubled HL", {reg_h, reg_l}, sum[15:0]);
      else
         chk({reg_h, reg_l} == sum[15:0], "R2 HL sum", {reg_h, reg_l}, sum[15:0]);
      chk(reg_f == {fv[7:1], sum[16]}, "R4 flags", reg_f, {fv[7:1], sum[16]});
      chk(reg_a == av, "R5 accumulator", reg_a, av);
      other = (pr == 0) ? {reg_b, reg_c} : (pr == 1) ? {reg_d, reg_e} : reg_sp;
      if (pr != 2) chk(other == src, "R2 source kept", other, src);
      if (noise)
         chk(reg_b == bc[15:8], "R10 write while busy ignored", reg_b, bc[15:8]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk({busy, done, bus_idle} == 3'b000, "R6 reset status", {busy, done, bus_idle}, 0);
      chk({reg_h, reg_l, reg_a, reg_f} == 32'h0, "R10 reset regs", {reg_h, reg_l, reg_a, reg_f}, 0);

      // R10 idle write visible next cycle
      wr(4'd6, 8'h5C);
      chk(reg_a == 8'h5C, "R10 idle write", reg_a, 8'h5C);

      // R1 invalid opcodes ignored
      wr(4'd4, 8'h12); wr(4'd5, 8'h34);
      foreach (opcode[i]) ;
      for (int t = 0; t < 3; t++) begin
         @(negedge clk);
         opcode = (t == 0) ? 8'h0A : (t == 1) ? 8'h49 : 8'h08;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk(busy == 1'b0, "R1 bad opcode no busy", busy, 0);
         @(negedge clk);
         chk({reg_h, reg_l} == 16'h1234, "R1 bad opcode no change", {reg_h, reg_l}, 16'h1234);
      end

      // R2 worked example
      run(0, 16'h5050, 16'h4050, 8'hA5, 8'h00, 1'b0);
      chk({reg_h, reg_l} == 16'h90A0, "R2 example", {reg_h, reg_l}, 16'h90A0);

      // Sweep: every pair, boundary operands, both carry-in values (R11), with noise (R9)
      for (int pr = 0; pr < 4; pr++)
         for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
               run(pr, pick(i), pick(j) ^ 16'(pr * 16'h0101), 8'(i * 37 + j),
                   {3'(i), 4'(j), 1'((i + j) & 1)}, ((i + j) % 3) == 0);

      // R11 explicit: carry preset set, low bytes do not carry
      run(0, 16'h0010, 16'h0020, 8'h01, 8'h01, 1'b0);
      chk({reg_h, reg_l} == 16'h0030, "R11 carry-in ignored", {reg_h, reg_l}, 16'h0030);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule